// File: doc/BRIEF.md
# Page-aware parallel flash read controller

This controller sits between a synchronous request port and an asynchronous parallel NOR flash bus. A read request carries a 23-bit word address. The controller turns it into a bus read: it drives the address, pulls chip select low, pulls output enable low at the right moment, and keeps write enable high. It waits a fixed number of clock cycles and then latches the 16-bit data bus. The word comes back on a response port as a single-cycle valid pulse. Only one read is in flight at a time.

The controller remembers the 8-word page that was last opened. The page is given by address bits 22 down to 3. A read that lands in the open page pays only the short page-access delay. Any other read pays the full random-access delay. The random delay, the page delay and the output-enable delay are parameters counted in clock cycles.

After a response, chip select stays low with output enable high for a bounded number of idle cycles. This keeps the page open for a following hit. When that window expires, the bus goes to standby and the page record is dropped. After reset the flash is already in read-array mode, so the controller never issues a command.

Top module: `flash_page_reader`

## Requirements
- R1: While rst_ni is low, flash_cs_no, flash_oe_no and flash_we_no are 1, flash_rst_no is 0 and rsp_valid_o is 0. One clock edge after reset is released, flash_rst_no is 1 and req_ready_o is 1.
- R2: flash_we_no is 1 in every cycle.
- R3: A request is accepted on a clock edge where req_valid_i and req_ready_o are both 1. req_ready_o then stays 0 until the response cycle. Requests presented while it is 0 are ignored, and so is any change to req_addr_i.
- R4: Let the acceptance edge be cycle 0. rsp_valid_o is 1 in cycle T_RAND+1 for a page miss and in cycle T_PAGE+1 for a page hit. It is 0 in the cycles between.
- R5: A read is a page hit only if all three of these hold:
  - its address bits 22:3 equal those of the previously accepted read;
  - chip select has stayed low since that read;
  - no reset has occurred since that read.
- R6: Access cycles are numbered k = 1 .. D, where D is the access delay. flash_oe_no is 0 in access cycle k exactly when the read is a hit or k >= T_OE. Outside access cycles it is 1.
- R7: flash_addr_o takes the accepted address in access cycle 1 and holds it until the next acceptance. flash_cs_no is 0 in every access cycle.
- R8: In the response cycle, rsp_data_o equals the flash data bus value present at the end of the last access cycle. rsp_valid_o is 1 for exactly one cycle.
- R9: Idle cycles after a response are numbered from 0, the response cycle itself. flash_cs_no stays 0 for idle cycles 0 .. IDLE_CYC-1 and becomes 1 from idle cycle IDLE_CYC on. From then on the page record is invalid.
- R10: The first read after any reset is a page miss, even when it targets the page that was open before the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Read request present |
| req_addr_i | input | 23 | Word address of the request |
| req_ready_o | output | 1 | Controller can accept a request |
| rsp_valid_o | output | 1 | One-cycle pulse: read data valid |
| rsp_data_o | output | 16 | Read data |
| flash_addr_o | output | 23 | Flash address bus |
| flash_cs_no | output | 1 | Flash chip select, active low |
| flash_oe_no | output | 1 | Flash output enable, active low |
| flash_we_no | output | 1 | Flash write enable, active low (held high) |
| flash_rst_no | output | 1 | Flash reset, active low |
| flash_dq_i | input | 16 | Flash data bus |

## Verification
A stale or missed page record shows up as a wrong response latency on the very next read. It is T_PAGE+1 instead of T_RAND+1, or the reverse. In the hit case, output enable also drops in access cycle 1 instead of cycle T_OE. A wrong access counter moves the sample point. The bench model drives the data bus only while chip select and output enable are both low, so sampling at the wrong point returns a wrong word in that same response. A wrong idle counter moves the rise of chip select by at least one cycle during the gap. It also changes whether the following read is a hit.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;
  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_ACCESS = 1'b1
  } rd_state_e;
endpackage

// File: rtl/frd_page_tracker.sv
module frd_page_tracker #(
  parameter int PAGE_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              clear_i,
  input  logic [PAGE_W-1:0] page_i,
  output logic              hit_o
);
  logic [PAGE_W-1:0] page_q;
  logic              valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q  <= '0;
      valid_q <= 1'b0;
    end else if (load_i) begin
      page_q  <= page_i;
      valid_q <= 1'b1;
    end else if (clear_i) begin
      valid_q <= 1'b0;
    end
  end

  assign hit_o = valid_q && (page_q == page_i);
endmodule

// File: rtl/frd_access_timer.sv
module frd_access_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] count_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q, lim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (start_i) begin
      cnt_q <= CNT_W'(1);
      lim_q <= limit_i;
    end else if (run_i && !done_o) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign count_o = cnt_q;
  assign done_o  = (cnt_q == lim_q);
endmodule

// File: rtl/frd_idle_timer.sv
module frd_idle_timer #(
  parameter int IDLE_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int IW = $clog2(IDLE_CYC + 1);

  logic [IW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (restart_i) begin
      cnt_q <= '0;
    end else if (tick_i && !expire_o) begin
      cnt_q <= cnt_q + IW'(1);
    end
  end

  assign expire_o = tick_i && (cnt_q == IW'(IDLE_CYC - 1));
endmodule

// File: rtl/flash_page_reader.sv
module flash_page_reader
  import flash_rd_pkg::*;
#(
  parameter int ADDR_W    = 23,
  parameter int DATA_W    = 16,
  parameter int WORD_BITS = 3,
  parameter int T_RAND    = 6,
  parameter int T_PAGE    = 2,
  parameter int T_OE      = 3,
  parameter int IDLE_CYC  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_ready_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic [ADDR_W-1:0] flash_addr_o,
  output logic              flash_cs_no,
  output logic              flash_oe_no,
  output logic              flash_we_no,
  output logic              flash_rst_no,
  input  logic [DATA_W-1:0] flash_dq_i
);
  localparam int PAGE_W = ADDR_W - WORD_BITS;
  localparam int CNT_W  = $clog2(T_RAND + 1);

  rd_state_e         state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              cs_n_q, hit_q, rsp_q, frst_n_q;

  logic              accept, page_hit, idle_expire, idle_tick, acc_done, in_access;
  logic [CNT_W-1:0]  acc_cnt, acc_limit;

  assign req_ready_o = (state_q == ST_IDLE);
  assign in_access   = (state_q == ST_ACCESS);
  assign accept      = req_valid_i && req_ready_o;
  assign idle_tick   = req_ready_o && !cs_n_q && !accept;
  assign acc_limit   = page_hit ? CNT_W'(T_PAGE) : CNT_W'(T_RAND);

  frd_page_tracker #(.PAGE_W(PAGE_W)) u_page (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .clear_i (idle_expire),
    .page_i  (req_addr_i[ADDR_W-1:WORD_BITS]),
    .hit_o   (page_hit)
  );

  frd_access_timer #(.CNT_W(CNT_W)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept),
    .run_i   (in_access),
    .limit_i (acc_limit),
    .count_o (acc_cnt),
    .done_o  (acc_done)
  );

  frd_idle_timer #(.IDLE_CYC(IDLE_CYC)) u_idle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (accept),
    .tick_i    (idle_tick),
    .expire_o  (idle_expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      data_q   <= '0;
      cs_n_q   <= 1'b1;
      hit_q    <= 1'b0;
      rsp_q    <= 1'b0;
      frst_n_q <= 1'b0;
    end else begin
      frst_n_q <= 1'b1;
      rsp_q    <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q <= ST_ACCESS;
            addr_q  <= req_addr_i;
            cs_n_q  <= 1'b0;
            hit_q   <= page_hit;
          end else if (idle_expire) begin
            cs_n_q  <= 1'b1;  // standby closes the page
          end
        end
        ST_ACCESS: begin
          if (acc_done) begin
            data_q  <= flash_dq_i;
            rsp_q   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // page hit: address already stable, enable output at once
  assign flash_oe_no  = !(in_access && (hit_q || acc_cnt >= CNT_W'(T_OE)));
  assign flash_cs_no  = cs_n_q;
  assign flash_we_no  = 1'b1;
  assign flash_rst_no = frst_n_q;
  assign flash_addr_o = addr_q;
  assign rsp_valid_o  = rsp_q;
  assign rsp_data_o   = data_q;
endmodule

// File: rtl/flash_page_reader_chk.sv
module flash_page_reader_chk #(
  parameter int ADDR_W = 23
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic [ADDR_W-1:0] flash_addr_o,
  input logic              flash_cs_no,
  input logic              flash_oe_no,
  input logic              flash_rst_no
);
  // R7
  busy_cs_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |-> !flash_cs_no);

  // R7
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |=> $stable(flash_addr_o));

  // R8
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  // R3
  rsp_when_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> req_ready_o);

  // R6
  oe_in_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flash_oe_no |-> (!flash_cs_no && !req_ready_o));

  // R1
  rst_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> flash_rst_no);
endmodule

bind flash_page_reader flash_page_reader_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/flash_page_reader_test.sv
module flash_page_reader_test;
  localparam int T_RAND   = 5;
  localparam int T_PAGE   = 2;
  localparam int T_OE     = 3;
  localparam int IDLE_CYC = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [22:0] req_addr_i = '0;
  logic        req_ready_o, rsp_valid_o;
  logic [15:0] rsp_data_o;
  logic [22:0] flash_addr_o;
  logic        flash_cs_no, flash_oe_no, flash_we_no, flash_rst_no;
  logic [15:0] flash_dq_i;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model state
  bit          opened = 0;
  int          idle_idx = 100;
  logic [19:0] page_m = '0;

  always #5 clk = ~clk;

  function automatic logic [15:0] mem_word(input logic [22:0] a);
    return a[15:0] ^ 16'h5A5A ^ {9'b0, a[22:16]};
  endfunction

  // flash model: drives real data only with chip and output enabled
  assign flash_dq_i = (!flash_cs_no && !flash_oe_no) ? mem_word(flash_addr_o) : 16'hDEAD;

  flash_page_reader #(
    .T_RAND(T_RAND), .T_PAGE(T_PAGE), .T_OE(T_OE), .IDLE_CYC(IDLE_CYC)
  ) uut (.*, .clk_i(clk));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [22:0] a, input int gap, input bit hold);
    bit hit;
    int d, n, bad_busy, bad_bus, bad_oe;
    for (int i = 0; i < gap; i++) begin
      @(negedge clk);
      idle_idx++;
      chk(flash_cs_no == !(opened && idle_idx < IDLE_CYC), "R9", "cs in idle gap",
          flash_cs_no, !(opened && idle_idx < IDLE_CYC));
      if (i == 0) chk(rsp_valid_o == 1'b0, "R8", "rsp pulse width", rsp_valid_o, 0);
    end
    // R5 hit model
    hit = opened && (idle_idx < IDLE_CYC) && (page_m == a[22:3]);
    d = hit ? T_PAGE : T_RAND;
    req_valid_i = 1'b1;
    req_addr_i  = a;
    @(negedge clk);
    if (hold) req_addr_i = ~a;
    else req_valid_i = 1'b0;
    bad_busy = 0; bad_bus = 0; bad_oe = 0;
    n = 1;
    while (n <= d) begin
      if (req_ready_o || rsp_valid_o) bad_busy++;
      if (flash_cs_no || !flash_we_no || flash_addr_o != a) bad_bus++;
      if (flash_oe_no != !(hit || n >= T_OE)) bad_oe++;
      @(negedge clk);
      n++;
    end
    req_valid_i = 1'b0;
    chk(bad_busy == 0, "R3", "busy during access", bad_busy, 0);
    chk(bad_bus == 0, "R7", "addr/cs/we during access", bad_bus, 0);
    chk(bad_oe == 0, "R6", "oe pattern", bad_oe, 0);
    chk(rsp_valid_o && req_ready_o, "R4", hit ? "hit latency" : "miss latency",
        rsp_valid_o, 1);
    chk(rsp_data_o == mem_word(a), "R8", "read data", rsp_data_o, mem_word(a));
    chk(flash_cs_no == 1'b0 && flash_oe_no == 1'b1 && flash_we_no == 1'b1, "R9",
        "output disable after rsp", {flash_cs_no, flash_oe_no, flash_we_no}, 3'b011);
    opened = 1; idle_idx = 0; page_m = a[22:3];
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    chk(flash_cs_no && flash_oe_no && flash_we_no && !flash_rst_no && !rsp_valid_o,
        "R1", "reset outputs",
        {flash_cs_no, flash_oe_no, flash_we_no, flash_rst_no, rsp_valid_o}, 5'b11100);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(flash_rst_no && req_ready_o, "R1", "after release",
        {flash_rst_no, req_ready_o}, 2'b11);
    opened = 0; idle_idx = 100;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R10 first read after reset misses
    rd(23'h000005, 0, 0);
    for (int g = 0; g <= 5; g++) begin
      for (int w = 0; w < 16; w++) begin
        logic [19:0] pg;
        pg = 20'h2A5C0 + 20'(g * 2) + 20'(w >> 3);
        rd({pg, 3'(w * 5)}, g, (w == 5));
      end
    end
    // R5 page boundaries at address extremes
    rd(23'h7FFFFF, 1, 0);
    rd(23'h7FFFF8, 1, 0);
    rd(23'h000000, 1, 0);
    rd(23'h000007, 3, 0);
    rd(23'h000008, 0, 0);
    // R2 write enable stays high across the run
    chk(flash_we_no == 1'b1, "R2", "we high", flash_we_no, 1);
    // R10 same page again after a reset is a miss
    rd(23'h012340, 0, 0);
    do_reset();
    rd(23'h012341, 0, 0);
    rd(23'h012342, 0, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule